// File: doc/BRIEF.md
# Floating-Point Compare Condition Coder

This block orders two operands held in an extended floating-point layout and turns the result into three condition bits (C3, C2, C0) in a status register. The first operand is the top of a register stack and the second is the source. Each operand arrives as a sign bit, a biased exponent and a mantissa whose most significant bit is the explicit integer bit. A single-cycle valid strobe starts a compare. The condition bits and an invalid-operation flag are registered on the clock edge that samples the strobe, and they hold until the next strobe.

A pop request that comes with the strobe turns the compare into the compare-and-pop form. The condition coding is the same, and the block also emits a one-cycle pop pulse that a stack controller outside the block consumes. An exponent of all ones marks the special class: a zero fraction below the integer bit means an infinity, and any non-zero fraction means a NaN. A NaN on either side makes the result unordered and raises the invalid flag.

Top module: `fpCmpCoder`

## Requirements
- R1: While rstN is low, and on the first clock after it, ccC3, ccC2, ccC0, invalidOp and popPulse are all 0.
- R2: If the first (stack) operand is greater than the source, the clock edge that samples cmpValid sets {ccC3,ccC2,ccC0} = 000.
- R3: If the first operand is less than the source, that edge sets {ccC3,ccC2,ccC0} = 001. Two negative values order opposite to their magnitudes.
- R4: If the operands are equal, that edge sets {ccC3,ccC2,ccC0} = 100. A zero is exponent 0 with mantissa 0, and +0 equals -0.
- R5: If either operand is a NaN (exponent all ones, mantissa bits below the top bit not all zero), that edge sets {ccC3,ccC2,ccC0} = 111 and invalidOp = 1. An ordered compare sets invalidOp = 0.
- R6: An infinity (exponent all ones, mantissa bits below the top bit zero) orders beyond every finite value. +inf against -inf codes greater, -inf against +inf codes less, and two infinities of the same sign code equal.
- R7: Outputs change only on the edge that samples cmpValid = 1. While cmpValid is 0, the operand inputs have no effect and the codes and invalidOp hold.
- R8: popPulse is 1 for exactly the cycle after an edge that samples cmpValid = 1 with popReq = 1, and is 0 otherwise. popReq without cmpValid produces no pulse.
- R9: The compare-and-pop form codes the same condition bits and invalidOp as the plain compare of the same operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmpValid | input | 1 | Compare strobe, one cycle per compare |
| popReq | input | 1 | Request a stack pop with this compare |
| stSign | input | 1 | Stack operand sign |
| stExp | input | EXP_W | Stack operand biased exponent |
| stMant | input | MAN_W | Stack operand mantissa, explicit integer bit on top |
| srcSign | input | 1 | Source operand sign |
| srcExp | input | EXP_W | Source operand biased exponent |
| srcMant | input | MAN_W | Source operand mantissa, explicit integer bit on top |
| ccC3 | output | 1 | Condition bit C3 |
| ccC2 | output | 1 | Condition bit C2 |
| ccC0 | output | 1 | Condition bit C0 |
| invalidOp | output | 1 | Last compare saw a NaN operand |
| popPulse | output | 1 | One-cycle stack pop request |

## Verification
The pop pulse and an unordered result can land in the same cycle. When that happens, the code register, the invalid flag and the pop output all change on one edge, and they are driven by different modules. The bench provokes this with compare-and-pop strobes that carry a NaN on either side, and also with compare-and-pop strobes issued back to back. A behavioural model judges all three outputs every cycle. A stray pop request with no strobe is also checked, so that it leaves both the codes and the pop line still.

// File: rtl/fpCmpPkg.sv
package fpCmpPkg;
  // Strobes the control hands to the datapath each cycle
  typedef struct packed {
    logic loadCodes;
    logic issuePop;
  } cmpStrobe_t;

  typedef enum logic [2:0] {
    CC_GREATER   = 3'b000,
    CC_LESS      = 3'b001,
    CC_EQUAL     = 3'b100,
    CC_UNORDERED = 3'b111
  } ccCode_e;
endpackage

// File: rtl/fpCmpControl.sv
module fpCmpControl
  import fpCmpPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmpValid,
  input  logic       popReq,
  output cmpStrobe_t strobe,
  output logic       popPulse
);
  always_comb begin
    strobe.loadCodes = cmpValid;
    strobe.issuePop  = cmpValid & popReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) popPulse <= 1'b0;
    else       popPulse <= strobe.issuePop;
  end

  // R8
  pop_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmpValid && popReq |=> popPulse);
  // R8
  pop_has_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    popPulse |-> $past(cmpValid) && $past(popReq));
endmodule

// File: rtl/fpCmpDatapath.sv
module fpCmpDatapath
  import fpCmpPkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  cmpStrobe_t       strobe,
  input  logic             stSign,
  input  logic [EXP_W-1:0] stExp,
  input  logic [MAN_W-1:0] stMant,
  input  logic             srcSign,
  input  logic [EXP_W-1:0] srcExp,
  input  logic [MAN_W-1:0] srcMant,
  output logic             ccC3,
  output logic             ccC2,
  output logic             ccC0,
  output logic             invalidOp
);
  localparam logic [EXP_W-1:0] EXP_SPECIAL = {EXP_W{1'b1}};
  localparam int               MAG_W       = EXP_W + MAN_W;

  logic             stNan, srcNan, unordered;
  logic             stZero, srcZero;
  logic [MAG_W-1:0] stMag, srcMag;
  logic             magGt, magEq;
  ccCode_e          nextCode;

  always_comb begin
    stNan     = (stExp == EXP_SPECIAL) && (stMant[MAN_W-2:0] != '0);
    srcNan    = (srcExp == EXP_SPECIAL) && (srcMant[MAN_W-2:0] != '0);
    unordered = stNan | srcNan;
    stZero    = (stExp == '0) && (stMant == '0);
    srcZero   = (srcExp == '0) && (srcMant == '0);
    stMag     = {stExp, stMant};
    srcMag    = {srcExp, srcMant};
    magGt     = stMag > srcMag;
    magEq     = stMag == srcMag;
  end

  always_comb begin
    if (unordered)
      nextCode = CC_UNORDERED;
    else if (stZero && srcZero)
      nextCode = CC_EQUAL;
    else if (stSign != srcSign)
      nextCode = stSign ? CC_LESS : CC_GREATER;
    else if (magEq)
      nextCode = CC_EQUAL;
    else if (magGt ^ stSign)
      nextCode = CC_GREATER;
    else
      nextCode = CC_LESS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {ccC3, ccC2, ccC0} <= 3'b000;
      invalidOp          <= 1'b0;
    end else if (strobe.loadCodes) begin
      {ccC3, ccC2, ccC0} <= nextCode;
      invalidOp          <= unordered;
    end
  end

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadCodes |=> $stable({ccC3, ccC2, ccC0, invalidOp}));
  // R5
  invalid_means_unordered_chk: assert property (@(posedge clk) disable iff (!rstN)
    invalidOp |-> ccC3 && ccC2 && ccC0);
  // R2
  legal_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    ccC2 |-> ccC3 && ccC0);
  // R4
  equal_xor_less_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ccC2 |-> $countones({ccC3, ccC0}) <= 1);
endmodule

// File: rtl/fpCmpCoder.sv
module fpCmpCoder
  import fpCmpPkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmpValid,
  input  logic             popReq,
  input  logic             stSign,
  input  logic [EXP_W-1:0] stExp,
  input  logic [MAN_W-1:0] stMant,
  input  logic             srcSign,
  input  logic [EXP_W-1:0] srcExp,
  input  logic [MAN_W-1:0] srcMant,
  output logic             ccC3,
  output logic             ccC2,
  output logic             ccC0,
  output logic             invalidOp,
  output logic             popPulse
);
  cmpStrobe_t strobe;

  fpCmpControl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmpValid (cmpValid),
    .popReq   (popReq),
    .strobe   (strobe),
    .popPulse (popPulse)
  );

  fpCmpDatapath #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .stSign    (stSign),
    .stExp     (stExp),
    .stMant    (stMant),
    .srcSign   (srcSign),
    .srcExp    (srcExp),
    .srcMant   (srcMant),
    .ccC3      (ccC3),
    .ccC2      (ccC2),
    .ccC0      (ccC0),
    .invalidOp (invalidOp)
  );
endmodule

// File: tb/fpCmpCoder_test.sv
module fpCmpCoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int EW = 15;
  localparam int MW = 64;
  localparam logic [EW-1:0] EX1 = 15'h7FFF;
  localparam logic [MW-1:0] INTB = 64'h8000_0000_0000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmpValid = 1'b0, popReq = 1'b0;
  logic stSign = 1'b0, srcSign = 1'b0;
  logic [EW-1:0] stExp = '0, srcExp = '0;
  logic [MW-1:0] stMant = '0, srcMant = '0;
  logic ccC3, ccC2, ccC0, invalidOp, popPulse;

  int checks = 0;
  int failures = 0;
  bit started = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpCmpCoder #(.EXP_W(EW), .MAN_W(MW)) uut (
    .clk(clk), .rstN(rstN), .cmpValid(cmpValid), .popReq(popReq),
    .stSign(stSign), .stExp(stExp), .stMant(stMant),
    .srcSign(srcSign), .srcExp(srcExp), .srcMant(srcMant),
    .ccC3(ccC3), .ccC2(ccC2), .ccC0(ccC0),
    .invalidOp(invalidOp), .popPulse(popPulse)
  );

  function automatic bit isNan(logic [EW-1:0] e, logic [MW-1:0] m);
    return (e == EX1) && (m[MW-2:0] != 0);
  endfunction

  function automatic logic signed [EW+MW:0] orderKey(logic s, logic [EW-1:0] e, logic [MW-1:0] m);
    logic signed [EW+MW:0] mag;
    if (e == 0 && m == 0) return '0;
    mag = $signed({1'b0, e, m});
    return s ? -mag : mag;
  endfunction

  function automatic logic [2:0] refCode();
    logic signed [EW+MW:0] ka, kb;
    if (isNan(stExp, stMant) || isNan(srcExp, srcMant)) return 3'b111;
    ka = orderKey(stSign, stExp, stMant);
    kb = orderKey(srcSign, srcExp, srcMant);
    if (ka == kb) return 3'b100;
    if (ka < kb)  return 3'b001;
    return 3'b000;
  endfunction

  function automatic string refTag();
    logic [2:0] c;
    c = refCode();
    if (c == 3'b111) return "R5";
    if (stExp == EX1 || srcExp == EX1) return "R6";
    if (popReq) return "R9";
    if (c == 3'b100) return "R4";
    if (c == 3'b001) return "R3";
    return "R2";
  endfunction

  // Behavioural reference model, one step per clock
  logic [2:0] expCc = 3'b000;
  logic expInv = 1'b0, expPop = 1'b0;
  string expTag = "R1";

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rstN) begin
      expCc <= 3'b000; expInv <= 1'b0; expPop <= 1'b0; expTag <= "R1";
    end else begin
      if (cmpValid) begin
        expCc  <= refCode();
        expInv <= isNan(stExp, stMant) || isNan(srcExp, srcMant);
        expTag <= refTag();
      end else begin
        expTag <= "R7";
      end
      expPop <= cmpValid && popReq;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if ({ccC3, ccC2, ccC0} !== expCc || invalidOp !== expInv) begin
        failures++;
        $display("FAIL %s cc=%b inv=%b expected cc=%b inv=%b at %0t",
                 expTag, {ccC3, ccC2, ccC0}, invalidOp, expCc, expInv, $time);
      end
      checks++;
      if (popPulse !== expPop) begin
        failures++;
        $display("FAIL R8 popPulse=%b expected %b at %0t", popPulse, expPop, $time);
      end
    end
  end

  task automatic apply(input logic sa, input logic [EW-1:0] ea, input logic [MW-1:0] ma,
                       input logic sb, input logic [EW-1:0] eb, input logic [MW-1:0] mb,
                       input logic v, input logic p);
    @(negedge clk); #1;
    stSign = sa; stExp = ea; stMant = ma;
    srcSign = sb; srcExp = eb; srcMant = mb;
    cmpValid = v; popReq = p;
  endtask

  function automatic logic [EW-1:0] rndExp();
    case ($urandom % 6)
      0: return '0;
      1: return EX1;
      2: return 15'h3FFF;
      3: return 15'h4000;
      default: return EW'($urandom);
    endcase
  endfunction

  function automatic logic [MW-1:0] rndMant(logic [EW-1:0] e);
    logic [MW-1:0] m;
    m = {$urandom, $urandom};
    case ($urandom % 4)
      0: m = (e == EX1) ? INTB : '0;
      1: m[MW-1] = 1'b1;
      default: ;
    endcase
    return m;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1 rstN = 1'b1;
    // R4: equal ones, +0 vs -0
    apply(0, 15'h3FFF, INTB, 0, 15'h3FFF, INTB, 1, 0);
    apply(0, 0, 0, 1, 0, 0, 1, 0);
    // R2 / R3: ordering of positives and negatives
    apply(0, 15'h4000, INTB, 0, 15'h3FFF, INTB, 1, 0);
    apply(0, 15'h3FFF, INTB, 0, 15'h4000, INTB, 1, 0);
    apply(1, 15'h4000, INTB, 1, 15'h3FFF, INTB, 1, 0);
    apply(1, 15'h3FFF, INTB, 0, 0, 0, 1, 0);
    apply(0, 15'h3FFF, INTB | 1, 0, 15'h3FFF, INTB, 1, 0);
    // R6: infinities
    apply(0, EX1, INTB, 1, EX1, INTB, 1, 0);
    apply(1, EX1, INTB, 0, EX1, INTB, 1, 0);
    apply(1, EX1, INTB, 1, EX1, INTB, 1, 0);
    apply(0, 15'h7FFE, '1, 0, EX1, INTB, 1, 0);
    // R5: NaN on either side, then an ordered compare clears invalid
    apply(0, EX1, INTB | 5, 0, 15'h3FFF, INTB, 1, 0);
    apply(0, 15'h3FFF, INTB, 1, EX1, 64'h1, 1, 0);
    apply(0, 15'h3FFF, INTB, 0, 15'h3FFF, INTB, 1, 0);
    // R7 / R8: idle inputs ignored, stray pop request ignored
    apply(1, EX1, 64'h3, 0, 0, 0, 0, 1);
    apply(0, 15'h4000, INTB, 1, 15'h4000, INTB, 0, 0);
    // R9: compare-and-pop, NaN with pop, back-to-back pops
    apply(1, 15'h3FFF, INTB, 0, 15'h3FFF, INTB, 1, 1);
    apply(0, EX1, INTB | 7, 0, 15'h3FFF, INTB, 1, 1);
    apply(0, 15'h4000, INTB, 0, 15'h3FFF, INTB, 1, 1);
    apply(0, 15'h4000, INTB, 0, 15'h3FFF, INTB, 0, 0);
    // Mixed random traffic across all classes
    for (int i = 0; i < 400; i++) begin
      logic [EW-1:0] ea, eb;
      logic [MW-1:0] ma, mb;
      logic sa, sb;
      ea = rndExp(); ma = rndMant(ea); sa = 1'($urandom);
      if ($urandom % 4 == 0) begin eb = ea; mb = ma; sb = ($urandom % 2 == 0) ? sa : ~sa; end
      else begin eb = rndExp(); mb = rndMant(eb); sb = 1'($urandom); end
      apply(sa, ea, ma, sb, eb, mb, ($urandom % 4) != 0, 1'($urandom));
    end
    apply(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    #2;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule